// File: doc/BRIEF.md
# Host Descriptor Ring Pointer Manager

This block tracks where the device stands in four circular descriptor rings held in host memory: transmit completion, receive completion, small free-buffer and big free-buffer. Each ring has a 28-bit pointer word in a small local control store. The upper 20 bits give the ring's 4K-aligned base, and the lower 8 bits give the index of the current 16-byte entry. For the selected ring and the selected word inside the entry, the block forms the 32-bit byte address that a DMA engine presents to the host.

The DMA engine fetches the first word of the current entry and shows it to the block. Bit 31 of that word tells whether the entry belongs to the device. The block keeps a not-owned flag per ring, and it accepts an advance strobe only while that flag is clear. An accepted advance steps the index by one with wraparound at 256 and leaves the base alone. It also marks the ring not-owned again, because the next entry has not yet been fetched. Host software loads pointer words through a single-word write port and can read them back through a read port.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After synchronous reset, all four pointer words read as zero and all four not-owned flags are 1.
- R2: A host write to word address 0, 1, 2 or 3 loads the transmit-completion, receive-completion, small free-buffer or big free-buffer pointer respectively, keeping data bits 27:0. The read port returns {4'h0, pointer} for addresses 0 to 3 in the same cycle, and the write is visible from the next cycle.
- R3: A host write to any word address of 4 or above changes no pointer and no flag, and the read port returns zero at those addresses.
- R4: dma_addr equals {pointer[27:0] of ring_sel, word_sel, 2'b00}, combinationally; its two low bits are always zero.
- R5: When fetch_vld is high, not_owned[ring_sel] becomes the inverse of fetch_word bit 31 on the next cycle (bit 31 = 1 means owned by the device).
- R6: An advance while not_owned[ring_sel] is 0 increments pointer bits 7:0 modulo 256 (255 wraps to 0), keeps bits 27:8, and sets not_owned[ring_sel] to 1, all visible on the next cycle.
- R7: An advance while not_owned[ring_sel] is 1 is ignored: the pointer does not change.
- R8: A host write to a ring's pointer word sets that ring's not-owned flag. When it coincides with an accepted advance of the same ring, the written value is stored and the increment is dropped.
- R9: An accepted advance and a fetch in the same cycle leave not_owned[ring_sel] at 1, whatever the fetched bit 31 is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host single-word write strobe |
| host_wr_addr | input | 14 | Control-store word address of the write |
| host_wr_data | input | 32 | Write data |
| host_rd_addr | input | 14 | Control-store word address of the read |
| host_rd_data | output | 32 | Read data (combinational) |
| ring_sel | input | 2 | Ring selected for address, fetch and advance |
| word_sel | input | 2 | Word inside the current entry |
| fetch_vld | input | 1 | First word of the current entry of ring_sel is present |
| fetch_word | input | 32 | That first word; bit 31 is the ownership flag |
| adv | input | 1 | Advance request for ring_sel |
| dma_addr | output | 32 | Host byte address of the selected word |
| not_owned | output | 4 | Per-ring flag: current entry is not usable |

## Verification
The address and read-data outputs are combinational, so the bench checks them in the same cycle as the stimulus, a short delay after the inputs settle. Pointer updates and flag changes come from a single register stage, so they are checked one clock edge later. The bench samples on the falling edge that follows the rising edge where the input was captured. A reference model applies the priority order of R8 and R9 at that same edge, and its prediction is compared only after the edge.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int unsigned RING_COUNT   = 4;
    localparam int unsigned RING_SEL_W   = $clog2(RING_COUNT);
    localparam int unsigned ENTRY_IDX_W  = 8;
    localparam int unsigned RING_BASE_W  = 20;
    localparam int unsigned PTR_W        = RING_BASE_W + ENTRY_IDX_W;
    localparam int unsigned ENTRY_WORDS  = 4;
    localparam int unsigned WORD_SEL_W   = $clog2(ENTRY_WORDS);
    localparam int unsigned BUS_W        = 32;
    localparam int unsigned STORE_AW     = 14;
    localparam int unsigned OWN_BIT      = 31;

    typedef enum logic [RING_SEL_W-1:0] {
        RING_TX_DONE  = 2'd0,
        RING_RX_DONE  = 2'd1,
        RING_FREE_SML = 2'd2,
        RING_FREE_BIG = 2'd3
    } ring_id_e;

    typedef struct packed {
        logic [RING_BASE_W-1:0] base;
        logic [ENTRY_IDX_W-1:0] idx;
    } ring_ptr_t;

    function automatic logic [RING_COUNT-1:0] sel_onehot(input logic [RING_SEL_W-1:0] sel);
        logic [RING_COUNT-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

    function automatic ring_ptr_t ptr_step(input ring_ptr_t p);
        ring_ptr_t n;
        n.base = p.base;
        n.idx  = p.idx + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/ring_ptr_store.sv
module ring_ptr_store
    import ring_ptr_pkg::*;
#(
    parameter int unsigned N_RINGS = RING_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_RINGS-1:0]       wr_hit,
    input  ring_ptr_t                wr_val,
    input  logic [N_RINGS-1:0]       adv_hit,
    output ring_ptr_t [N_RINGS-1:0]  ptr_q
);

    for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (wr_hit[g]) begin
                ptr_q[g] <= wr_val;
            end else if (adv_hit[g]) begin
                ptr_q[g] <= ptr_step(ptr_q[g]);
            end
        end
    end

endmodule

// File: rtl/ring_own_track.sv
module ring_own_track
    import ring_ptr_pkg::*;
#(
    parameter int unsigned N_RINGS = RING_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RINGS-1:0] wr_hit,
    input  logic [N_RINGS-1:0] adv_hit,
    input  logic [N_RINGS-1:0] fetch_hit,
    input  logic               fetch_owned,
    output logic [N_RINGS-1:0] not_owned_q
);

    for (genvar g = 0; g < N_RINGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                not_owned_q[g] <= 1'b1;
            end else if (wr_hit[g] || adv_hit[g]) begin
                not_owned_q[g] <= 1'b1;
            end else if (fetch_hit[g]) begin
                not_owned_q[g] <= ~fetch_owned;
            end
        end
    end

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_ptr_pkg::*;
#(
    parameter int unsigned N_RINGS = RING_COUNT,
    parameter int unsigned SEL_W   = RING_SEL_W,
    parameter int unsigned AW      = STORE_AW
) (
    input  ring_ptr_t [N_RINGS-1:0] ptr_q,
    input  logic [SEL_W-1:0]        ring_sel,
    input  logic [WORD_SEL_W-1:0]   word_sel,
    input  logic [AW-1:0]           rd_addr,
    output logic [BUS_W-1:0]        dma_addr,
    output logic [BUS_W-1:0]        rd_data
);

    localparam int unsigned PAD_W = BUS_W - PTR_W;

    ring_ptr_t sel_ptr;
    logic      rd_in_range;

    always_comb begin
        sel_ptr  = ptr_q[ring_sel];
        dma_addr = {sel_ptr, word_sel, 2'b00};
    end

    always_comb begin
        rd_in_range = (rd_addr < AW'(N_RINGS));
        rd_data     = '0;
        if (rd_in_range) begin
            rd_data = {{PAD_W{1'b0}}, ptr_q[rd_addr[SEL_W-1:0]]};
        end
    end

endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
    import ring_ptr_pkg::*;
#(
    parameter int unsigned N_RINGS = RING_COUNT,
    parameter int unsigned SEL_W   = RING_SEL_W,
    parameter int unsigned AW      = STORE_AW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr_en,
    input  logic [AW-1:0]         host_wr_addr,
    input  logic [BUS_W-1:0]      host_wr_data,
    input  logic [AW-1:0]         host_rd_addr,
    output logic [BUS_W-1:0]      host_rd_data,
    input  logic [SEL_W-1:0]      ring_sel,
    input  logic [WORD_SEL_W-1:0] word_sel,
    input  logic                  fetch_vld,
    input  logic [BUS_W-1:0]      fetch_word,
    input  logic                  adv,
    output logic [BUS_W-1:0]      dma_addr,
    output logic [N_RINGS-1:0]    not_owned
);

    logic [N_RINGS-1:0]      sel_vec;
    logic [N_RINGS-1:0]      wr_hit;
    logic [N_RINGS-1:0]      adv_hit;
    logic [N_RINGS-1:0]      fetch_hit;
    ring_ptr_t               wr_val;
    ring_ptr_t [N_RINGS-1:0] ptr_q;

    always_comb begin
        sel_vec   = sel_onehot(ring_sel);
        wr_val    = ring_ptr_t'(host_wr_data[PTR_W-1:0]);
        wr_hit    = '0;
        if (host_wr_en && (host_wr_addr < AW'(N_RINGS))) begin
            wr_hit = sel_onehot(host_wr_addr[SEL_W-1:0]);
        end
        adv_hit   = adv       ? (sel_vec & ~not_owned) : '0;
        fetch_hit = fetch_vld ? sel_vec : '0;
    end

    ring_ptr_store #(.N_RINGS(N_RINGS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .wr_val  (wr_val),
        .adv_hit (adv_hit),
        .ptr_q   (ptr_q)
    );

    ring_own_track #(.N_RINGS(N_RINGS)) u_own (
        .clk         (clk),
        .rst         (rst),
        .wr_hit      (wr_hit),
        .adv_hit     (adv_hit),
        .fetch_hit   (fetch_hit),
        .fetch_owned (fetch_word[OWN_BIT]),
        .not_owned_q (not_owned)
    );

    ring_addr_gen #(.N_RINGS(N_RINGS), .SEL_W(SEL_W), .AW(AW)) u_addr (
        .ptr_q    (ptr_q),
        .ring_sel (ring_sel),
        .word_sel (word_sel),
        .rd_addr  (host_rd_addr),
        .dma_addr (dma_addr),
        .rd_data  (host_rd_data)
    );

endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk
    import ring_ptr_pkg::*;
#(
    parameter int unsigned N_RINGS = RING_COUNT,
    parameter int unsigned SEL_W   = RING_SEL_W,
    parameter int unsigned AW      = STORE_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_wr_en,
    input  logic [AW-1:0]           host_wr_addr,
    input  logic [BUS_W-1:0]        host_wr_data,
    input  logic [SEL_W-1:0]        ring_sel,
    input  logic                    fetch_vld,
    input  logic [BUS_W-1:0]        fetch_word,
    input  logic                    adv,
    input  logic [BUS_W-1:0]        dma_addr,
    input  logic [N_RINGS-1:0]      not_owned,
    input  ring_ptr_t [N_RINGS-1:0] ptr_q
);

    logic      rst_seen_q;
    logic      wr_any_ring;
    logic      wr_same_ring;
    ring_ptr_t cur_ptr;

    always_ff @(posedge clk) rst_seen_q <= rst;

    always_comb begin
        wr_any_ring  = host_wr_en && (host_wr_addr < AW'(N_RINGS));
        wr_same_ring = wr_any_ring && (host_wr_addr[SEL_W-1:0] == ring_sel);
        cur_ptr      = ptr_q[ring_sel];
    end

    AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
        rst_seen_q |-> (not_owned == '1 && ptr_q == '0)); // R1

    AST_HI_ADDR_IGN: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !wr_any_ring && !adv && !fetch_vld) |=> ($stable(ptr_q) && $stable(not_owned))); // R3

    AST_FETCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !adv && !wr_same_ring) |=>
            (not_owned[$past(ring_sel)] == !$past(fetch_word[OWN_BIT]))); // R5

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !not_owned[ring_sel] && !wr_same_ring) |=>
            (ptr_q[$past(ring_sel)].idx  == $past(cur_ptr.idx) + 8'd1 &&
             ptr_q[$past(ring_sel)].base == $past(cur_ptr.base) &&
             not_owned[$past(ring_sel)])); // R6

    AST_ADV_STALL: assert property (@(posedge clk) disable iff (rst)
        (adv && not_owned[ring_sel] && !wr_same_ring) |=>
            (ptr_q[$past(ring_sel)] == $past(cur_ptr))); // R7

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_any_ring |=>
            (ptr_q[$past(host_wr_addr[SEL_W-1:0])] == $past(host_wr_data[PTR_W-1:0]) &&
             not_owned[$past(host_wr_addr[SEL_W-1:0])])); // R8

    AST_ADDR_WORD: assert property (@(posedge clk) disable iff (rst)
        (dma_addr[1:0] == 2'b00 && dma_addr[BUS_W-1:4] == cur_ptr)); // R4

endmodule

bind ring_ptr_mgr ring_ptr_chk #(.N_RINGS(N_RINGS), .SEL_W(SEL_W), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .host_wr_data (host_wr_data),
    .ring_sel     (ring_sel),
    .fetch_vld    (fetch_vld),
    .fetch_word   (fetch_word),
    .adv          (adv),
    .dma_addr     (dma_addr),
    .not_owned    (not_owned),
    .ptr_q        (ptr_q)
);

// File: tb/ring_ptr_mgr_bench.sv
module ring_ptr_mgr_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en;
    logic [13:0] host_wr_addr;
    logic [31:0] host_wr_data;
    logic [13:0] host_rd_addr;
    logic [31:0] host_rd_data;
    logic [1:0]  ring_sel;
    logic [1:0]  word_sel;
    logic        fetch_vld;
    logic [31:0] fetch_word;
    logic        adv;
    logic [31:0] dma_addr;
    logic [3:0]  not_owned;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [27:0] m_ptr [4];
    logic [3:0]  m_nown;

    always #4 clk = ~clk;

    ring_ptr_mgr u_ring_ptr_mgr (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .host_rd_addr (host_rd_addr),
        .host_rd_data (host_rd_data),
        .ring_sel     (ring_sel),
        .word_sel     (word_sel),
        .fetch_vld    (fetch_vld),
        .fetch_word   (fetch_word),
        .adv          (adv),
        .dma_addr     (dma_addr),
        .not_owned    (not_owned)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_dma(input logic [1:0] r, input logic [1:0] w);
        return {m_ptr[r], w, 2'b00};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [13:0] a);
        return (a < 14'd4) ? {4'h0, m_ptr[a[1:0]]} : 32'h0;
    endfunction

    task automatic idle();
        host_wr_en = 0; host_wr_addr = '0; host_wr_data = '0;
        fetch_vld = 0; fetch_word = '0; adv = 0;
    endtask

    // Inputs already driven; check combinational outputs, apply the edge, update the model.
    task automatic step(input string req);
        logic acc;
        logic wr_hit;
        #1;
        check({req, "/R4 dma_addr"}, dma_addr, exp_dma(ring_sel, word_sel));
        check({req, "/R2 rd_data"}, host_rd_data, exp_rd(host_rd_addr));
        @(posedge clk);
        acc    = adv && !m_nown[ring_sel];
        wr_hit = host_wr_en && host_wr_addr < 14'd4;
        if (acc) begin
            m_ptr[ring_sel][7:0] = m_ptr[ring_sel][7:0] + 8'd1;
            m_nown[ring_sel] = 1'b1;
        end else if (fetch_vld) begin
            m_nown[ring_sel] = ~fetch_word[31];
        end
        if (wr_hit) begin
            m_ptr[host_wr_addr[1:0]]  = host_wr_data[27:0];
            m_nown[host_wr_addr[1:0]] = 1'b1;
        end
        @(negedge clk);
        check({req, "/R5 not_owned"}, {28'h0, not_owned}, {28'h0, m_nown});
    endtask

    task automatic hwrite(input logic [13:0] a, input logic [31:0] d);
        idle(); host_wr_en = 1; host_wr_addr = a; host_wr_data = d;
        step("R2 write");
    endtask

    task automatic fetch(input logic [1:0] r, input logic own);
        idle(); ring_sel = r; fetch_vld = 1; fetch_word = {own, 31'h1234};
        step("R5 fetch");
    endtask

    task automatic advance(input logic [1:0] r);
        idle(); ring_sel = r; adv = 1;
        step("R6 advance");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; idle(); ring_sel = 0; word_sel = 0; host_rd_addr = 0;
        for (int i = 0; i < 4; i++) m_ptr[i] = '0;
        m_nown = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 not_owned", {28'h0, not_owned}, 32'hF);
        for (int a = 0; a < 4; a++) begin
            host_rd_addr = 14'(a); #1;
            check("R1 pointer zero", host_rd_data, 32'h0);
        end
        // R2: load with high bits set; they are dropped
        hwrite(14'd1, 32'hF0ABCDFF);
        host_rd_addr = 14'd1; #1;
        check("R2 readback", host_rd_data, 32'h00ABCDFF);
        // R3: write above pointer words ignored
        host_rd_addr = 14'd4;
        hwrite(14'd4, 32'h0FFFFFFF);
        hwrite(14'h3FFF, 32'h0FFFFFFF);
        host_rd_addr = 14'd0; #1;
        check("R3 ptr0 untouched", host_rd_data, 32'h0);
        // R7: advance while not owned ignored
        advance(2'd1);
        host_rd_addr = 14'd1; #1;
        check("R7 stalled", host_rd_data, 32'h00ABCDFF);
        // R6: wrap 255 -> 0
        fetch(2'd1, 1'b1);
        check("R5 owned clears flag", {31'h0, not_owned[1]}, 32'h0);
        advance(2'd1);
        host_rd_addr = 14'd1; #1;
        check("R6 wrap", host_rd_data, 32'h00ABCD00);
        check("R6 flag set", {31'h0, not_owned[1]}, 32'h1);
        // R9: advance and fetch together
        fetch(2'd2, 1'b1);
        idle(); ring_sel = 2'd2; adv = 1; fetch_vld = 1; fetch_word = 32'h80000000;
        step("R9 adv+fetch");
        check("R9 flag", {31'h0, not_owned[2]}, 32'h1);
        // R8: write and advance same ring same cycle
        fetch(2'd3, 1'b1);
        idle(); ring_sel = 2'd3; adv = 1; host_wr_en = 1; host_wr_addr = 14'd3; host_wr_data = 32'h05555510;
        step("R8 collision");
        host_rd_addr = 14'd3; #1;
        check("R8 write wins", host_rd_data, 32'h05555510);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            idle();
            ring_sel     = 2'($urandom);
            word_sel     = 2'($urandom);
            host_rd_addr = (r[3:0] == 0) ? 14'($urandom) : 14'($urandom_range(0, 5));
            if (r[7:5] == 0) begin
                host_wr_en   = 1;
                host_wr_addr = (r[8]) ? 14'($urandom) : 14'($urandom_range(0, 5));
                host_wr_data = $urandom;
            end
            fetch_vld  = (r[10:9] != 0);
            fetch_word = {r[11] | r[12], 31'($urandom)};
            adv        = r[13] | r[14];
            step("R6 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule